// File: doc/BRIEF.md
# Cascaded Serial DAC Chain Loader

This block runs on the host side of a chain of identical 12-bit serial DACs that are wired in cascade: each DAC's serial output feeds the data input of the next DAC. The host loads one 12-bit value per device through a valid/ready interface. The first value accepted is meant for the device farthest from the host, and the last value accepted is meant for the nearest device. When the last of the `N_DEV` values arrives, the block starts one transfer without further help. It pulls the frame sync line low and clocks out `N_DEV` 16-bit frames as one unbroken burst. Each frame holds four zero pad bits followed by the value, most significant bit first. The block then raises sync and drives one shared load strobe low, so that every DAC output changes at the same moment.

All serial timing is taken from counts of the system clock. `HALF_CLKS` sets the length of each half of the serial clock, and `STROBE_CLKS` sets how long the load strobe stays low. The serial clock rests high. The block changes the data line on the serial clock's rising edge, and the devices sample it on the falling edge, so the data has half a period to settle. The sequencer has five states:
- `ST_COLLECT`: gathering words. It moves to `ST_LEAD` when the final word is accepted.
- `ST_LEAD`: sync is low and the clock is held high. It moves to `ST_SHIFT` after `HALF_CLKS` cycles.
- `ST_SHIFT`: the clock toggles. It moves to `ST_TAIL` when the low phase of the last bit ends.
- `ST_TAIL`: sync is high. It moves to `ST_STROBE` after `HALF_CLKS` cycles.
- `ST_STROBE`: the load strobe is low. It returns to `ST_COLLECT` after `STROBE_CLKS` cycles.

Top module: `dcl_chain_loader`

## Requirements
- R1: During reset and right after it, `dac_sync_n`, `dac_sclk` and `dac_ldac_n` are 1, `dac_sdin` is 0, `busy` is 0 and `in_ready` is 1.
- R2: A word is taken on each rising clock edge at which `in_valid` and `in_ready` are both 1. After the edge that takes the `N_DEV`-th word, `in_ready` is 0 until the load strobe has ended. At all other times it is 1.
- R3: While sync is high, the serial clock is high. After sync falls, the serial clock stays high for `HALF_CLKS` cycles. It then alternates low and high every `HALF_CLKS` cycles and gives exactly 16·`N_DEV` falling edges under one sync-low period.
- R4: Each 16-bit frame carries four 0 bits first and then the 12-bit value, most significant bit first. The value's bit 0 is the last bit of the frame.
- R5: Frames leave in the order their words were accepted. The first accepted word is the first frame on the line.
- R6: `dac_sdin` changes only in the cycle where the serial clock rises or sync falls. It is constant while the serial clock is low.
- R7: Sync rises together with the serial clock rise that ends the last low phase, which is 2·`HALF_CLKS`·16·`N_DEV` cycles after sync fell.
- R8: The load strobe falls `HALF_CLKS` cycles after sync rises and stays low for `STROBE_CLKS` cycles. It is low only while sync is high.
- R9: `busy` goes to 1 on the edge that takes any word. It stays 1 until the edge at which the load strobe returns high, where it goes to 0.
- R10: Words offered while `in_ready` is 0 are dropped. They never appear in any later frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Host offers a channel value |
| in_ready | output | 1 | Block can take a value this cycle |
| in_data | input | VAL_W | Channel value; the farthest device's value comes first |
| busy | output | 1 | Set from the first taken value until the load strobe ends |
| dac_sync_n | output | 1 | Frame sync to the chain, active low |
| dac_sclk | output | 1 | Serial clock to the chain, rests high |
| dac_sdin | output | 1 | Serial data into the nearest device |
| dac_ldac_n | output | 1 | Shared load strobe, active low |

## Verification
The hardest condition to reach is a host that keeps offering words while a transfer is running. Words offered then must be dropped and must not leak into the next batch. To get there, the stimulus holds `in_valid` high with a marker value for a window inside the second burst and drops it before `in_ready` comes back. It then checks that the third batch's frames hold only the words offered afterwards. The batches also mix back-to-back offers with spaced offers, and use all-ones, all-zeros and alternating-bit values. This places the pad bits and the most significant bits next to both kinds of neighbour.

// File: rtl/dcl_pkg.sv
`timescale 1ns/1ps
package dcl_pkg;
    localparam int PAD_W   = 4;
    localparam int VAL_W   = 12;
    localparam int FRAME_W = PAD_W + VAL_W;

    typedef enum logic [2:0] {
        ST_COLLECT,
        ST_LEAD,
        ST_SHIFT,
        ST_TAIL,
        ST_STROBE
    } dcl_state_e;
endpackage

// File: rtl/dcl_word_store.sv
`timescale 1ns/1ps
module dcl_word_store #(
    parameter int N_DEV = 4,
    parameter int VAL_W = 12,
    parameter int SEL_W = (N_DEV > 1) ? $clog2(N_DEV) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [VAL_W-1:0] wr_data,
    input  logic [SEL_W-1:0] rd_sel,
    output logic [VAL_W-1:0] rd_data,
    output logic             last_wr
);
    logic [VAL_W-1:0] mem_q [N_DEV];
    logic [SEL_W-1:0] wr_ptr_q;

    assign last_wr = wr_en && (wr_ptr_q == SEL_W'(N_DEV - 1));

    always_ff @(posedge clk) begin
        if (!rst_n)
            wr_ptr_q <= '0;
        else if (wr_en)
            wr_ptr_q <= last_wr ? '0 : wr_ptr_q + 1'b1;
    end

    for (genvar i = 0; i < N_DEV; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (wr_en && wr_ptr_q == SEL_W'(i))
                mem_q[i] <= wr_data;
        end
    end

    assign rd_data = (int'(rd_sel) < N_DEV) ? mem_q[rd_sel] : '0;

    // R2
    wr_ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(wr_ptr_q) < N_DEV);
endmodule

// File: rtl/dcl_bit_pick.sv
`timescale 1ns/1ps
module dcl_bit_pick #(
    parameter int PAD_W = 4,
    parameter int VAL_W = 12,
    parameter int POS_W = $clog2(PAD_W + VAL_W)
) (
    input  logic [VAL_W-1:0] word,
    input  logic [POS_W-1:0] pos,
    output logic             bit_o
);
    always_comb begin
        bit_o = 1'b0;
        for (int i = 0; i < VAL_W; i++) begin
            if (int'(pos) == PAD_W + i)
                bit_o = word[VAL_W-1-i];
        end
    end
endmodule

// File: rtl/dcl_chain_loader.sv
`timescale 1ns/1ps
module dcl_chain_loader
    import dcl_pkg::*;
#(
    parameter int N_DEV       = 4,
    parameter int HALF_CLKS   = 5,
    parameter int STROBE_CLKS = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [VAL_W-1:0] in_data,
    output logic             busy,
    output logic             dac_sync_n,
    output logic             dac_sclk,
    output logic             dac_sdin,
    output logic             dac_ldac_n
);
    localparam int TOTAL_BITS = FRAME_W * N_DEV;
    localparam int IDX_W      = $clog2(TOTAL_BITS + 1);
    localparam int SEL_W      = (N_DEV > 1) ? $clog2(N_DEV) : 1;
    localparam int POS_W      = $clog2(FRAME_W);
    localparam int TCNT_MAX   = (HALF_CLKS > STROBE_CLKS) ? HALF_CLKS : STROBE_CLKS;
    localparam int TCNT_W     = $clog2(TCNT_MAX + 1);

    dcl_state_e        state_q, state_d;
    logic [TCNT_W-1:0] tcnt_q;
    logic [IDX_W-1:0]  bit_idx_q;
    logic              sync_n_q, sclk_q, sdin_q, ldac_n_q, busy_q;

    logic              accept, last_wr, tmo, last_bit, pick_bit;
    logic [IDX_W-1:0]  pick_idx;
    logic [SEL_W-1:0]  rd_sel;
    logic [POS_W-1:0]  pick_pos;
    logic [VAL_W-1:0]  rd_word;

    assign in_ready = (state_q == ST_COLLECT);
    assign accept   = in_valid && in_ready;
    assign tmo      = (tcnt_q == '0);
    assign last_bit = (bit_idx_q == IDX_W'(TOTAL_BITS - 1));
    assign pick_idx = (state_q == ST_COLLECT) ? '0 : bit_idx_q + 1'b1;
    assign rd_sel   = SEL_W'(pick_idx / IDX_W'(FRAME_W));
    assign pick_pos = POS_W'(pick_idx % IDX_W'(FRAME_W));

    dcl_word_store #(.N_DEV(N_DEV), .VAL_W(VAL_W), .SEL_W(SEL_W)) store_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (accept),
        .wr_data (in_data),
        .rd_sel  (rd_sel),
        .rd_data (rd_word),
        .last_wr (last_wr)
    );

    dcl_bit_pick #(.PAD_W(PAD_W), .VAL_W(VAL_W), .POS_W(POS_W)) pick_i (
        .word  (rd_word),
        .pos   (pick_pos),
        .bit_o (pick_bit)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_COLLECT: if (accept && last_wr)           state_d = ST_LEAD;
            ST_LEAD:    if (tmo)                         state_d = ST_SHIFT;
            ST_SHIFT:   if (tmo && !sclk_q && last_bit)  state_d = ST_TAIL;
            ST_TAIL:    if (tmo)                         state_d = ST_STROBE;
            ST_STROBE:  if (tmo)                         state_d = ST_COLLECT;
            default:                                     state_d = ST_COLLECT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_COLLECT;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tcnt_q    <= '0;
            bit_idx_q <= '0;
            sync_n_q  <= 1'b1;
            sclk_q    <= 1'b1;
            sdin_q    <= 1'b0;
            ldac_n_q  <= 1'b1;
            busy_q    <= 1'b0;
        end else begin
            if (accept) busy_q <= 1'b1;
            unique case (state_q)
                ST_COLLECT: begin
                    if (accept && last_wr) begin
                        sync_n_q  <= 1'b0;
                        sclk_q    <= 1'b1;
                        sdin_q    <= pick_bit;
                        bit_idx_q <= '0;
                        tcnt_q    <= TCNT_W'(HALF_CLKS - 1);
                    end
                end
                ST_LEAD: begin
                    if (tmo) begin
                        sclk_q <= 1'b0;
                        tcnt_q <= TCNT_W'(HALF_CLKS - 1);
                    end else begin
                        tcnt_q <= tcnt_q - 1'b1;
                    end
                end
                ST_SHIFT: begin
                    if (tmo) begin
                        tcnt_q <= TCNT_W'(HALF_CLKS - 1);
                        if (sclk_q) begin
                            sclk_q <= 1'b0;
                        end else if (last_bit) begin
                            sclk_q   <= 1'b1;
                            sync_n_q <= 1'b1;
                        end else begin
                            sclk_q    <= 1'b1;
                            bit_idx_q <= bit_idx_q + 1'b1;
                            sdin_q    <= pick_bit;
                        end
                    end else begin
                        tcnt_q <= tcnt_q - 1'b1;
                    end
                end
                ST_TAIL: begin
                    if (tmo) begin
                        ldac_n_q <= 1'b0;
                        tcnt_q   <= TCNT_W'(STROBE_CLKS - 1);
                    end else begin
                        tcnt_q <= tcnt_q - 1'b1;
                    end
                end
                ST_STROBE: begin
                    if (tmo) begin
                        ldac_n_q <= 1'b1;
                        busy_q   <= 1'b0;
                    end else begin
                        tcnt_q <= tcnt_q - 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    assign busy       = busy_q;
    assign dac_sync_n = sync_n_q;
    assign dac_sclk   = sclk_q;
    assign dac_sdin   = sdin_q;
    assign dac_ldac_n = ldac_n_q;

    // R3
    idle_sclk_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dac_sync_n |-> dac_sclk);
    // R6
    sdin_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dac_sclk |-> $stable(dac_sdin));
    // R8
    ldac_after_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dac_ldac_n |-> dac_sync_n);
    // R9
    busy_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dac_sync_n || !dac_ldac_n) |-> busy);
    // R2
    ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (dac_sync_n && dac_ldac_n));
endmodule

// File: tb/dcl_chain_loader_tb.sv
`timescale 1ns/1ps
module dcl_chain_loader_tb_top;
    localparam int N  = 4;
    localparam int H  = 5;
    localparam int L  = 3;
    localparam int KT = 2 * H * 16 * N;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [11:0] in_data = '0;
    logic        in_ready, busy, dac_sync_n, dac_sclk, dac_sdin, dac_ldac_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    dcl_chain_loader #(.N_DEV(N), .HALF_CLKS(H), .STROBE_CLKS(L)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .busy(busy), .dac_sync_n(dac_sync_n),
        .dac_sclk(dac_sclk), .dac_sdin(dac_sdin), .dac_ldac_n(dac_ldac_n)
    );

    // behavioural reference
    int          k = 0;
    bit          collecting = 1;
    bit          m_busy = 0;
    bit          m_sdin = 0;
    logic [11:0] pend[$];
    logic [11:0] frame[$];
    string       frame_tag = "R5";

    function automatic bit bitval(int b);
        int w = b / 16;
        int p = b % 16;
        if (p < 4) return 1'b0;
        return frame[w][15-p];
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            collecting = 1; m_busy = 0; m_sdin = 0; k = 0; pend.delete();
        end else if (collecting) begin
            if (in_valid) begin
                pend.push_back(in_data);
                m_busy = 1;
                if (pend.size() == N) begin
                    frame = pend; pend.delete();
                    collecting = 0; k = 0; m_sdin = bitval(0);
                end
            end
        end else begin
            k++;
            if (k < KT) m_sdin = bitval(k / (2 * H));
            if (k == KT + H + L) begin collecting = 1; m_busy = 0; end
        end
    end

    task automatic chk(string tag, logic act, logic exp, string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: %s actual=%0b expected=%0b (k=%0d)", tag, what, act, exp, k);
        end
    endtask

    logic        prev_sclk = 1, prev_sync = 1, prev_sdin = 0;
    logic        cap[$];

    always @(negedge clk) begin
        if (rst_n) begin
            bit e_sync, e_sclk, e_ldac;
            e_sync = collecting ? 1'b1 : (k < KT ? 1'b0 : 1'b1);
            e_sclk = (collecting || k >= KT) ? 1'b1 : (((k / H) % 2) == 0);
            e_ldac = (!collecting && k >= KT + H && k < KT + H + L) ? 1'b0 : 1'b1;
            chk("R2", in_ready, collecting, "in_ready");
            chk("R3", dac_sclk, e_sclk, "serial clock");
            chk("R4", dac_sdin, m_sdin, "serial data");
            chk("R7", dac_sync_n, e_sync, "sync");
            chk("R8", dac_ldac_n, e_ldac, "load strobe");
            chk("R9", busy, m_busy, "busy");
            // R6: data moves only on a clock rise or sync fall
            if (dac_sdin !== prev_sdin) begin
                checks++;
                if (!((dac_sclk && !prev_sclk) || (!dac_sync_n && prev_sync))) begin
                    fails++;
                    $display("FAIL R6: data changed off a rising edge actual=%0b expected=%0b", dac_sdin, prev_sdin);
                end
            end
            if (!dac_sync_n && prev_sclk && !dac_sclk) cap.push_back(dac_sdin);
            if (dac_sync_n && !prev_sync) begin
                int bad;
                checks++;
                if (cap.size() != 16 * N) begin
                    fails++;
                    $display("FAIL R3: falling edges actual=%0d expected=%0d", cap.size(), 16 * N);
                end
                bad = -1;
                for (int b = 0; b < 16 * N && b < cap.size(); b++)
                    if (cap[b] !== bitval(b) && bad < 0) bad = b;
                checks++;
                if (bad >= 0) begin
                    fails++;
                    $display("FAIL %s: captured bit %0d actual=%0b expected=%0b", frame_tag, bad, cap[bad], bitval(bad));
                end
                cap.delete();
            end
        end
        prev_sclk = dac_sclk; prev_sync = dac_sync_n; prev_sdin = dac_sdin;
    end

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    task automatic send_word(logic [11:0] w, int gap);
        repeat (gap) @(negedge clk);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        #1 in_valid = 1; in_data = w;
        @(negedge clk);
        #1 in_valid = 0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        chk("R1", dac_sync_n, 1'b1, "reset sync");
        chk("R1", dac_sclk,   1'b1, "reset sclk");
        chk("R1", dac_ldac_n, 1'b1, "reset strobe");
        chk("R1", dac_sdin,   1'b0, "reset data");
        chk("R1", busy,       1'b0, "reset busy");
        chk("R1", in_ready,   1'b1, "reset ready");
        #1 rst_n = 1;
        // batch 1: back to back
        send_word(12'hA5C, 0); send_word(12'h0FF, 0);
        send_word(12'hFFF, 0); send_word(12'h001, 0);
        wait_idle();
        // batch 2: spaced offers, then junk offered mid-transfer (R10)
        send_word(12'h123, 3); send_word(12'h000, 1);
        send_word(12'hFFF, 7); send_word(12'hE01, 2);
        repeat (10) @(negedge clk);
        #1 in_valid = 1; in_data = 12'hBAD;
        repeat (30) @(negedge clk);
        checks++;
        if (in_ready !== 1'b0) begin
            fails++;
            $display("FAIL R10: in_ready during transfer actual=%0b expected=0", in_ready);
        end
        #1 in_valid = 0;
        wait_idle();
        // batch 3: frames must not contain the dropped marker
        frame_tag = "R10";
        send_word(12'h800, 0); send_word(12'h7FF, 2);
        send_word(12'h555, 0); send_word(12'hAAA, 5);
        wait_idle();
        finish_up();
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL R2: watchdog actual=timeout expected=completion");
        finish_up();
    end
endmodule